// File: doc/BRIEF.md
# Lockable Two-Way Set-Associative Data Cache

This block is a two-way set-associative data cache that sits between a processor load/store port and a simple burst memory. Each way holds 8 KB and is one lockable unit, so the default geometry is 16 KB with 32-byte lines read and written as four 64-bit beats. The set index is taken from the virtual address, while the tag compare uses a physical tag that arrives in the same cycle, so lookup and translation overlap. A load that hits returns its 64-bit beat on the next clock edge.

On a load miss, the cache asks the memory for a four-beat burst at the line-aligned physical address. It writes each beat as it arrives and sets the tag after the last one. It then replays the stalled load against the arrays. A lock input with one bit per way keeps a way out of victim selection while that way holds a valid line, so critical lines stay resident. When both ways are unlocked and both are valid, a free-running LFSR picks the victim.

Every data byte carries its own parity bit and every tag carries one parity bit. A load that finds a parity mismatch on a matching line raises an error pulse and refills that line. Stores are write-through and do not allocate on a miss. A test input inverts the parity written by a store, so that the check can be exercised.

Top module: `lkc_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `mem_req`, `mem_wr` and `par_err` are 0, and every line is invalid, so the first load to any address misses.
- R2: A load accepted while `req_ready` is high that hits gives `rsp_valid`=1 and `rsp_hit`=1 one edge later, with `rsp_rdata` holding the 64-bit beat selected by `req_vaddr[4:3]`, and issues no `mem_req`.
- R3: A load miss raises `mem_req` for exactly one cycle, with `mem_addr` = {`req_ptag`, `req_vaddr[12:5]`, 5'b0}. The four `mem_rsp_valid` beats arrive in beat order 0..3 and are written into the line. The load is then answered with `rsp_hit`=0 and the requested beat, and later loads to any beat of that line hit.
- R4: When neither way is locked, an invalid way is filled before a valid one (way 0 before way 1), so two tags that share a set are both resident after two misses.
- R5: `lock_ways[w]`=1 (registered, so it takes effect one cycle later) keeps a valid line in way w from being chosen as a victim. A miss on that set then refills the other way.
- R6: If both ways of the set are locked and valid, a load miss is still answered with the memory data (`rsp_hit`=0) but allocates nothing, so repeating it misses again, and the locked lines still hit.
- R7: A locked way whose line in the set is invalid may still be filled, and the new line then hits.
- R8: A store raises `mem_wr` for one cycle with `mem_wr_addr` = {`req_ptag`, `req_vaddr`}, the store's byte enables and its data. It answers with `rsp_hit`=1 if the tag matched, and a hitting store changes only the enabled bytes of the cached beat.
- R9: A store miss allocates no line, so a later load to that address misses.
- R10: A load whose tag matches a line with a data-byte or tag parity mismatch raises `par_err` for one cycle, together with `mem_req`. It refills that same way and returns the memory data with `rsp_hit`=0. A store with `par_inject`=1 writes inverted parity for its enabled bytes. Loads of clean lines never raise `par_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_ways | input | 2 | Per-way lock bits, bit w locks way w |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 13 | Virtual set index, beat and byte offset |
| req_ptag | input | 19 | Physical tag, same cycle as the index |
| req_be | input | 8 | Store byte enables |
| req_wdata | input | 64 | Store data |
| par_inject | input | 1 | Test: invert parity written by a store |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Access was served by a matching line |
| rsp_rdata | output | 64 | Load data |
| par_err | output | 1 | One-cycle parity error pulse |
| mem_req | output | 1 | One-cycle burst read request |
| mem_addr | output | 32 | Line-aligned burst address |
| mem_rsp_valid | input | 1 | Burst beat valid |
| mem_rsp_data | input | 64 | Burst beat data |
| mem_wr | output | 1 | One-cycle write-through request |
| mem_wr_addr | output | 32 | Write-through byte address |
| mem_wr_be | output | 8 | Write-through byte enables |
| mem_wr_data | output | 64 | Write-through data |

## Verification
The assertions assume the memory sends `mem_rsp_valid` only while a burst is outstanding and delivers exactly four beats per request. They also assume that a replayed load finds the line it has just filled, which holds only if no store to that set slips in during the refill. The bench keeps to these assumptions: it answers each `mem_req` with four back-to-back beats from a byte-merged memory model, and it issues a new request only after the previous response has arrived. Lock changes are made only between accesses, with idle cycles after them.

// File: rtl/lkc_pkg.sv
package lkc_pkg;
  localparam int WAYS = 2;
  typedef enum logic [1:0] {
    FSM_IDLE   = 2'd0,
    FSM_FILL   = 2'd1,
    FSM_REPLAY = 2'd2
  } fill_state_t;
endpackage

// File: rtl/lkc_way.sv
// One way: tag+parity array, valid bits, data array with per-byte parity.
module lkc_way #(
  parameter int SETS   = 256,
  parameter int BEATS  = 4,
  parameter int TAG_W  = 19,
  parameter int DATA_W = 64,
  localparam int NB     = DATA_W / 8,
  localparam int SET_W  = $clog2(SETS),
  localparam int BEAT_W = $clog2(BEATS),
  localparam int DEPTH  = SETS * BEATS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [BEAT_W-1:0] rd_beat,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_tag_par,
  output logic [DATA_W-1:0] rd_data,
  output logic [NB-1:0]     rd_par,
  input  logic              d_we,
  input  logic [SET_W-1:0]  d_set,
  input  logic [BEAT_W-1:0] d_beat,
  input  logic [NB-1:0]     d_be,
  input  logic [DATA_W-1:0] d_wdata,
  input  logic [NB-1:0]     d_wpar,
  input  logic              t_we,
  input  logic [SET_W-1:0]  t_set,
  input  logic [TAG_W-1:0]  t_tag
);
  logic [DATA_W-1:0] dmem [DEPTH];
  logic [NB-1:0]     pmem [DEPTH];
  logic [TAG_W:0]    tmem [SETS];
  logic [SETS-1:0]   vbits;

  always_ff @(posedge clk) begin
    if (d_we) begin
      for (int b = 0; b < NB; b++) begin
        if (d_be[b]) begin
          dmem[{d_set, d_beat}][8*b +: 8] <= d_wdata[8*b +: 8];
          pmem[{d_set, d_beat}][b]        <= d_wpar[b];
        end
      end
    end
    if (t_we) tmem[t_set] <= {^t_tag, t_tag};
  end

  always_ff @(posedge clk) begin
    if (rst)       vbits <= '0;
    else if (t_we) vbits[t_set] <= 1'b1;
  end

  assign rd_valid   = vbits[rd_set];
  assign rd_tag     = tmem[rd_set][TAG_W-1:0];
  assign rd_tag_par = tmem[rd_set][TAG_W];
  assign rd_data    = dmem[{rd_set, rd_beat}];
  assign rd_par     = pmem[{rd_set, rd_beat}];

  // R3: a tag write leaves the line valid on the next cycle
  assert_tag_sets_valid_R3: assert property (@(posedge clk) disable iff (rst)
    t_we |=> vbits[$past(t_set)]);
endmodule

// File: rtl/lkc_victim.sv
// Victim choice: skip locked valid ways, prefer invalid, else LFSR bit.
module lkc_victim (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] valid,
  input  logic [1:0] lock,
  output logic       victim,
  output logic       alloc
);
  localparam int LFSR_W = 16;
  logic [LFSR_W-1:0] lfsr;
  logic [1:0]        elig;

  always_ff @(posedge clk) begin
    if (rst) lfsr <= 16'h0001;
    else     lfsr <= {lfsr[LFSR_W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always_comb begin
    elig  = ~(lock & valid);
    alloc = |elig;
    if (elig == 2'b11) begin
      if (!valid[0])      victim = 1'b0;
      else if (!valid[1]) victim = 1'b1;
      else                victim = lfsr[0];
    end else begin
      victim = ~elig[0];
    end
  end

  // R5: an allocating choice never lands on a locked valid way
  assert_skip_locked_R5: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !(lock[victim] && valid[victim]));
  // R6: no allocation only when both ways are locked and valid
  assert_noalloc_full_R6: assert property (@(posedge clk) disable iff (rst)
    !alloc |-> (lock == 2'b11 && valid == 2'b11));
endmodule

// File: rtl/lkc_refill.sv
// Line refill sequencer: request, count beats, replay.
module lkc_refill
  import lkc_pkg::*;
#(
  parameter int BEATS   = 4,
  parameter int PADDR_W = 32,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [PADDR_W-1:0] start_addr,
  input  logic               alloc,
  input  logic               mem_rsp_valid,
  output fill_state_t        state,
  output logic [BEAT_W-1:0]  beat,
  output logic               fill_we,
  output logic               fill_last,
  output logic               mem_req,
  output logic [PADDR_W-1:0] mem_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= FSM_IDLE;
      beat     <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else begin
      mem_req <= 1'b0;
      case (state)
        FSM_IDLE: if (start) begin
          state    <= FSM_FILL;
          beat     <= '0;
          mem_req  <= 1'b1;
          mem_addr <= start_addr;
        end
        FSM_FILL: if (mem_rsp_valid) begin
          beat <= beat + 1'b1;
          if (beat == BEAT_W'(BEATS - 1)) state <= alloc ? FSM_REPLAY : FSM_IDLE;
        end
        default: state <= FSM_IDLE;
      endcase
    end
  end

  assign fill_we   = (state == FSM_FILL) && mem_rsp_valid;
  assign fill_last = fill_we && (beat == BEAT_W'(BEATS - 1));

  // R3: burst request is a single-cycle pulse issued on entry to the fill
  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  assert_req_in_fill_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (state == FSM_FILL && beat == '0));
  // R3: the replay lasts exactly one cycle
  assert_replay_once_R3: assert property (@(posedge clk) disable iff (rst)
    (state == FSM_REPLAY) |=> (state == FSM_IDLE));
endmodule

// File: rtl/lkc_cache.sv
module lkc_cache
  import lkc_pkg::*;
#(
  parameter int SETS    = 256,
  parameter int BEATS   = 4,
  parameter int DATA_W  = 64,
  parameter int PADDR_W = 32,
  localparam int NB      = DATA_W / 8,
  localparam int SET_W   = $clog2(SETS),
  localparam int BEAT_W  = $clog2(BEATS),
  localparam int OFF_W   = $clog2(NB),
  localparam int LINE_W  = BEAT_W + OFF_W,
  localparam int VADDR_W = SET_W + LINE_W,
  localparam int TAG_W   = PADDR_W - VADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WAYS-1:0]    lock_ways,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_we,
  input  logic [VADDR_W-1:0] req_vaddr,
  input  logic [TAG_W-1:0]   req_ptag,
  input  logic [NB-1:0]      req_be,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               par_inject,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               par_err,
  output logic               mem_req,
  output logic [PADDR_W-1:0] mem_addr,
  input  logic               mem_rsp_valid,
  input  logic [DATA_W-1:0]  mem_rsp_data,
  output logic               mem_wr,
  output logic [PADDR_W-1:0] mem_wr_addr,
  output logic [NB-1:0]      mem_wr_be,
  output logic [DATA_W-1:0]  mem_wr_data
);
  fill_state_t       st;
  logic [BEAT_W-1:0] fbeat;
  logic              fill_we, fill_last;
  logic [WAYS-1:0]   lock_q;
  logic [SET_W-1:0]  sv_set;
  logic [BEAT_W-1:0] sv_beat;
  logic [TAG_W-1:0]  sv_tag;
  logic              vic_q, alloc_q;
  logic [DATA_W-1:0] cap;

  logic              idle, replay, accept;
  logic [SET_W-1:0]  lk_set;
  logic [BEAT_W-1:0] lk_beat;
  logic [TAG_W-1:0]  lk_tag;

  logic              w_valid [WAYS];
  logic [TAG_W-1:0]  w_tag   [WAYS];
  logic              w_tpar  [WAYS];
  logic [DATA_W-1:0] w_data  [WAYS];
  logic [NB-1:0]     w_par   [WAYS];
  logic [WAYS-1:0]   match, bad, hit_w, d_we, t_we;
  logic              dbad, hit, perr, ld_miss;
  logic [DATA_W-1:0] hdata;
  logic [NB-1:0]     fill_par, st_par;
  logic              vic, alloc, vic_sel, alloc_sel;

  assign idle      = (st == FSM_IDLE);
  assign replay    = (st == FSM_REPLAY);
  assign req_ready = idle;
  assign accept    = idle && req_valid;
  assign lk_set    = replay ? sv_set  : req_vaddr[VADDR_W-1:LINE_W];
  assign lk_beat   = replay ? sv_beat : req_vaddr[LINE_W-1:OFF_W];
  assign lk_tag    = replay ? sv_tag  : req_ptag;

  // Lookup and parity check of both ways
  always_comb begin
    dbad = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      dbad = 1'b0;
      for (int b = 0; b < NB; b++)
        dbad = dbad | ((^w_data[w][8*b +: 8]) != w_par[w][b]);
      match[w] = w_valid[w] && (w_tag[w] == lk_tag);
      bad[w]   = match[w] && (((^w_tag[w]) != w_tpar[w]) || dbad);
    end
    for (int b = 0; b < NB; b++) begin
      fill_par[b] = ^mem_rsp_data[8*b +: 8];
      st_par[b]   = (^req_wdata[8*b +: 8]) ^ par_inject;
    end
  end

  assign hit_w   = match & ~bad;
  assign hit     = |hit_w;
  assign perr    = |bad;
  assign hdata   = hit_w[1] ? w_data[1] : w_data[0];
  assign ld_miss = accept && !req_we && !hit;

  lkc_victim u_victim (
    .clk(clk), .rst(rst),
    .valid({w_valid[1], w_valid[0]}), .lock(lock_q),
    .victim(vic), .alloc(alloc)
  );
  // A corrupt line is refilled in place, lock or not
  assign vic_sel   = perr ? bad[1] : vic;
  assign alloc_sel = perr || alloc;

  lkc_refill #(.BEATS(BEATS), .PADDR_W(PADDR_W)) u_refill (
    .clk(clk), .rst(rst), .start(ld_miss),
    .start_addr({req_ptag, req_vaddr[VADDR_W-1:LINE_W], {LINE_W{1'b0}}}),
    .alloc(alloc_q), .mem_rsp_valid(mem_rsp_valid),
    .state(st), .beat(fbeat), .fill_we(fill_we), .fill_last(fill_last),
    .mem_req(mem_req), .mem_addr(mem_addr)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign d_we[w] = (fill_we && alloc_q && (vic_q == 1'(w))) ||
                     (accept && req_we && match[w]);
    assign t_we[w] = fill_last && alloc_q && (vic_q == 1'(w));
    lkc_way #(.SETS(SETS), .BEATS(BEATS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_way (
      .clk(clk), .rst(rst),
      .rd_set(lk_set), .rd_beat(lk_beat),
      .rd_valid(w_valid[w]), .rd_tag(w_tag[w]), .rd_tag_par(w_tpar[w]),
      .rd_data(w_data[w]), .rd_par(w_par[w]),
      .d_we(d_we[w]),
      .d_set(fill_we ? sv_set : lk_set),
      .d_beat(fill_we ? fbeat : lk_beat),
      .d_be(fill_we ? {NB{1'b1}} : req_be),
      .d_wdata(fill_we ? mem_rsp_data : req_wdata),
      .d_wpar(fill_we ? fill_par : st_par),
      .t_we(t_we[w]), .t_set(sv_set), .t_tag(sv_tag)
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_rdata <= '0; par_err <= 1'b0;
      mem_wr <= 1'b0; mem_wr_addr <= '0; mem_wr_be <= '0; mem_wr_data <= '0;
      lock_q <= '0; sv_set <= '0; sv_beat <= '0; sv_tag <= '0;
      vic_q <= 1'b0; alloc_q <= 1'b0; cap <= '0;
    end else begin
      lock_q    <= lock_ways;
      rsp_valid <= 1'b0;
      par_err   <= 1'b0;
      mem_wr    <= 1'b0;
      if (accept) begin
        if (req_we) begin
          mem_wr      <= 1'b1;
          mem_wr_addr <= {req_ptag, req_vaddr};
          mem_wr_be   <= req_be;
          mem_wr_data <= req_wdata;
          rsp_valid   <= 1'b1;
          rsp_hit     <= |match;
        end else if (hit) begin
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b1;
          rsp_rdata <= hdata;
        end else begin
          sv_set  <= lk_set;
          sv_beat <= lk_beat;
          sv_tag  <= lk_tag;
          vic_q   <= vic_sel;
          alloc_q <= alloc_sel;
          par_err <= perr;
        end
      end
      if (fill_we && fbeat == sv_beat) cap <= mem_rsp_data;
      if (fill_last && !alloc_q) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b0;
        rsp_rdata <= (fbeat == sv_beat) ? mem_rsp_data : cap;
      end
      if (replay) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b0;
        rsp_rdata <= hdata;
      end
    end
  end

  // R10: a parity error is always reported together with the refill request
  assert_err_with_refill_R10: assert property (@(posedge clk) disable iff (rst)
    par_err |-> mem_req);
  // R3: the replay always finds the freshly filled line intact
  assert_replay_hits_R3: assert property (@(posedge clk) disable iff (rst)
    replay |-> hit);
  // R8: an accepted store is written through and answered on the next edge
  assert_store_through_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && req_we) |=> (mem_wr && rsp_valid && !mem_req));
  // R2: an accepted load that hits is answered next edge with no memory traffic
  assert_hit_no_mem_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && !req_we && hit) |=> (rsp_valid && rsp_hit && !mem_req));
endmodule

// File: tb/lkc_cache_tb.sv
`timescale 1ns/1ps
module lkc_cache_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  lock_ways = 2'b00;
  logic        req_valid = 1'b0, req_we = 1'b0, par_inject = 1'b0;
  logic        req_ready;
  logic [12:0] req_vaddr = '0;
  logic [18:0] req_ptag = '0;
  logic [7:0]  req_be = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, rsp_hit, par_err, mem_req, mem_wr;
  logic [63:0] rsp_rdata, mem_wr_data;
  logic [31:0] mem_addr, mem_wr_addr;
  logic [7:0]  mem_wr_be;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  always #2 clk = ~clk;  // 250 MHz

  lkc_cache u_dut (
    .clk(clk), .rst(rst), .lock_ways(lock_ways),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_vaddr(req_vaddr), .req_ptag(req_ptag), .req_be(req_be),
    .req_wdata(req_wdata), .par_inject(par_inject),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .par_err(par_err), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_wr(mem_wr), .mem_wr_addr(mem_wr_addr), .mem_wr_be(mem_wr_be),
    .mem_wr_data(mem_wr_data)
  );

  int checks = 0, errs = 0;
  int mreq_cnt = 0, perr_cnt = 0, mwr_cnt = 0, left = 0;
  logic [31:0] base = '0, last_req_addr = '0, last_wr_addr = '0;
  logic [7:0]  last_wr_be = '0;
  logic [63:0] mem_m [logic [31:0]];

  function automatic logic [63:0] mrd(input logic [31:0] a);
    if (mem_m.exists(a)) return mem_m[a];
    return {a ^ 32'h5A5A_0000, ~a};
  endfunction

  function automatic logic [31:0] pa(input logic [18:0] t, input logic [7:0] s, input logic [1:0] b);
    return {t, s, b, 3'b000};
  endfunction

  // Memory model and monitors, sampled 1 ns after the rising edge
  always @(posedge clk) begin
    #1;
    if (mem_req) begin base = mem_addr; left = 4; mreq_cnt++; last_req_addr = mem_addr; end
    if (mem_wr) begin
      logic [63:0] d;
      d = mrd({mem_wr_addr[31:3], 3'b000});
      for (int b = 0; b < 8; b++) if (mem_wr_be[b]) d[8*b +: 8] = mem_wr_data[8*b +: 8];
      mem_m[{mem_wr_addr[31:3], 3'b000}] = d;
      mwr_cnt++; last_wr_addr = mem_wr_addr; last_wr_be = mem_wr_be;
    end
    if (par_err) perr_cnt++;
    if (left > 0) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mrd(base + 32'(8 * (4 - left)));
      left--;
    end else begin
      mem_rsp_valid = 1'b0;
    end
  end

  task automatic chk(input bit ok, input int rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic do_acc(input logic we, input logic [18:0] tag, input logic [7:0] set,
                        input logic [1:0] beat, input logic [7:0] be,
                        input logic [63:0] wd, input logic inj, input int rq,
                        output logic hit, output logic [63:0] data);
    int n;
    @(negedge clk);
    mreq_cnt = 0; perr_cnt = 0; mwr_cnt = 0;
    req_valid = 1'b1; req_we = we; req_ptag = tag; req_vaddr = {set, beat, 3'b000};
    req_be = be; req_wdata = wd; par_inject = inj;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0; par_inject = 1'b0;
    n = 0;
    while (!rsp_valid && n < 60) begin @(negedge clk); n++; end
    chk(rsp_valid, rq, "response timeout", 64'(rsp_valid), 64'd1);
    hit = rsp_hit; data = rsp_rdata;
  endtask

  typedef struct packed {
    logic [1:0] lock; logic we; logic [7:0] tag; logic [7:0] set;
    logic [1:0] beat; logic [7:0] be; logic hit; logic mreq; logic [3:0] rq;
  } vec_t;
  localparam int NV = 19;
  // tags: A=1 B=2 C=3 D=4 in set 5, E=5 in set 9, F=6 in set 5
  localparam vec_t TBL [NV] = '{
    '{2'b00, 1'b0, 8'd1, 8'd5, 2'd0, 8'hFF, 1'b0, 1'b1, 4'd1},  // R1 first load misses
    '{2'b00, 1'b0, 8'd1, 8'd5, 2'd2, 8'hFF, 1'b1, 1'b0, 4'd2},  // R2 hit, beat 2
    '{2'b00, 1'b0, 8'd1, 8'd5, 2'd3, 8'hFF, 1'b1, 1'b0, 4'd3},  // R3 other beat of line hits
    '{2'b00, 1'b0, 8'd2, 8'd5, 2'd1, 8'hFF, 1'b0, 1'b1, 4'd3},  // R3 B miss
    '{2'b00, 1'b0, 8'd1, 8'd5, 2'd0, 8'hFF, 1'b1, 1'b0, 4'd4},  // R4 A still resident
    '{2'b00, 1'b0, 8'd2, 8'd5, 2'd1, 8'hFF, 1'b1, 1'b0, 4'd4},  // R4 B resident
    '{2'b01, 1'b0, 8'd3, 8'd5, 2'd0, 8'hFF, 1'b0, 1'b1, 4'd5},  // R5 C evicts way1
    '{2'b01, 1'b0, 8'd1, 8'd5, 2'd0, 8'hFF, 1'b1, 1'b0, 4'd5},  // R5 locked A kept
    '{2'b01, 1'b0, 8'd2, 8'd5, 2'd1, 8'hFF, 1'b0, 1'b1, 4'd5},  // R5 B was evicted
    '{2'b01, 1'b0, 8'd3, 8'd5, 2'd0, 8'hFF, 1'b0, 1'b1, 4'd5},  // R5 C evicted by B
    '{2'b11, 1'b0, 8'd4, 8'd5, 2'd2, 8'hFF, 1'b0, 1'b1, 4'd6},  // R6 no allocate
    '{2'b11, 1'b0, 8'd4, 8'd5, 2'd2, 8'hFF, 1'b0, 1'b1, 4'd6},  // R6 misses again
    '{2'b11, 1'b0, 8'd1, 8'd5, 2'd1, 8'hFF, 1'b1, 1'b0, 4'd6},  // R6 locked A hits
    '{2'b11, 1'b0, 8'd5, 8'd9, 2'd3, 8'hFF, 1'b0, 1'b1, 4'd7},  // R7 locked invalid filled
    '{2'b11, 1'b0, 8'd5, 8'd9, 2'd3, 8'hFF, 1'b1, 1'b0, 4'd7},  // R7 now hits
    '{2'b01, 1'b1, 8'd1, 8'd5, 2'd1, 8'h0F, 1'b1, 1'b0, 4'd8},  // R8 store hit, low bytes
    '{2'b01, 1'b0, 8'd1, 8'd5, 2'd1, 8'hFF, 1'b1, 1'b0, 4'd8},  // R8 merged data
    '{2'b01, 1'b1, 8'd6, 8'd5, 2'd0, 8'hFF, 1'b0, 1'b0, 4'd9},  // R9 store miss
    '{2'b01, 1'b0, 8'd6, 8'd5, 2'd0, 8'hFF, 1'b0, 1'b1, 4'd9}   // R9 no allocation
  };

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
  endtask

  initial begin
    #(200000 * 4);
    errs++;
    $display("FAIL all watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic h;
    logic [63:0] d, wd;
    logic [31:0] a;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, 1, "req_ready after reset", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, 1, "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk(mem_req == 1'b0 && mem_wr == 1'b0, 1, "mem_req/mem_wr after reset",
        64'({mem_req, mem_wr}), 64'd0);
    chk(par_err == 1'b0, 1, "par_err after reset", 64'(par_err), 64'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t e;
      e = TBL[i];
      lock_ways = e.lock;
      repeat (2) @(negedge clk);
      wd = 64'hC3C3_0000_0000_0000 | 64'(i * 32'h0101_0101);
      a  = pa(19'(e.tag), e.set, e.beat);
      do_acc(e.we, 19'(e.tag), e.set, e.beat, e.be, wd, 1'b0, int'(e.rq), h, d);
      repeat (2) @(negedge clk);
      chk(h == e.hit, int'(e.rq), $sformatf("vector %0d rsp_hit", i), 64'(h), 64'(e.hit));
      chk(mreq_cnt == int'(e.mreq), int'(e.rq), $sformatf("vector %0d mem_req count", i),
          64'(mreq_cnt), 64'(e.mreq));
      if (e.mreq)
        chk(last_req_addr == {a[31:5], 5'b0}, 3, $sformatf("vector %0d mem_addr", i),
            64'(last_req_addr), 64'({a[31:5], 5'b0}));
      if (e.we) begin
        chk(mwr_cnt == 1 && last_wr_addr == a && last_wr_be == e.be, 8,
            $sformatf("vector %0d write-through", i), 64'(last_wr_addr), 64'(a));
      end else begin
        chk(d == mrd(a), int'(e.rq), $sformatf("vector %0d rsp_rdata", i), d, mrd(a));
      end
      chk(perr_cnt == 0, 10, $sformatf("vector %0d no parity error", i), 64'(perr_cnt), 64'd0);
    end

    // R10 parity: corrupt beat 2 of line A via a store, then load it
    a = pa(19'd1, 8'd5, 2'd2);
    do_acc(1'b1, 19'd1, 8'd5, 2'd2, 8'hF0, 64'h1122_3344_5566_7788, 1'b1, 10, h, d);
    repeat (2) @(negedge clk);
    chk(h == 1'b1, 10, "corrupting store hits", 64'(h), 64'd1);
    do_acc(1'b0, 19'd1, 8'd5, 2'd2, 8'hFF, 64'd0, 1'b0, 10, h, d);
    repeat (2) @(negedge clk);
    chk(perr_cnt == 1, 10, "par_err pulse count", 64'(perr_cnt), 64'd1);
    chk(mreq_cnt == 1, 10, "refill after parity error", 64'(mreq_cnt), 64'd1);
    chk(h == 1'b0, 10, "parity error load not a hit", 64'(h), 64'd0);
    chk(d == mrd(a), 10, "parity error load data", d, mrd(a));
    do_acc(1'b0, 19'd1, 8'd5, 2'd2, 8'hFF, 64'd0, 1'b0, 10, h, d);
    repeat (2) @(negedge clk);
    chk(h == 1'b1 && perr_cnt == 0, 10, "refilled line clean hit",
        64'({h, 1'b0, perr_cnt[0]}), 64'h4);
    chk(d == mrd(a), 10, "refilled line data", d, mrd(a));

    summary();
    $finish;
  end
endmodule